// File: doc/BRIEF.md
# Hamming Check-Bit Generator with Scannable Error Flag

This block computes the check bits of a modified Hamming code over one data byte. It has four check bits with a fixed, irregular coverage in which data bit 0 is left out of all four, and a fifth bit that is the parity of the whole byte. The byte parity is then adjusted by an even/odd select and combined with an external byte-parity input. The result is a word-parity bit, which a larger error-correction scheme uses to compare a stored byte against its stored parity. Wider words are built by placing one instance per byte next to wider parity trees.

The word-parity bit is captured in a single flag register, which is presented as a true and complement pair of error flags. The flag has three behaviours. It can load the word parity, keep its value, or take a serial input so that it can sit as one stage of a scan chain. All parity outputs are combinational. Only the flag changes on the clock.

Top module: `hamming_parity_scan`

## Requirements
- R1: `chk_o[0]` equals the XOR of data bits 1, 3, 5 and 7.
- R2: `chk_o[1]` equals the XOR of data bits 2, 3, 6 and 7.
- R3: `chk_o[2]` equals the XOR of data bits 4, 5, 6 and 7, and `chk_o[3]` equals the XOR of data bits 1, 2, 4 and 7.
- R4: `byte_par_o` is the XOR of all eight data bits.
- R5: `word_par_o` equals `byte_par_o` XOR `bpar_i` XOR `odd_sel_i`. With `odd_sel_i`=0 it is 0 when the byte and `bpar_i` together hold an even count of ones.
- R6: On a rising clock edge with `en_n_i`=1, the flag keeps its value whatever the other control inputs are.
- R7: On a rising clock edge with `en_n_i`=0 and `shift_i`=1, the flag takes `scan_i`. Shift overrides hold.
- R8: On a rising clock edge with `en_n_i`=0, `shift_i`=0 and `hold_n_i`=0, the flag keeps its value.
- R9: On a rising clock edge with `en_n_i`=0, `shift_i`=0 and `hold_n_i`=1, the flag takes the current `word_par_o`.
- R10: While `rst_n` is low, the flag is 0 at once (`err_o`=0, `err_n_o`=1). After `rst_n` rises, the flag stays 0 for two more clock edges.
- R11: `err_n_o` is always the complement of `err_o`.
- R12: The check bits, the byte parity and the word parity follow the inputs in the same cycle, with no register in their path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| data_i | input | 8 | Data byte |
| odd_sel_i | input | 1 | Parity sense: 0 selects even, 1 selects odd |
| bpar_i | input | 1 | External byte-parity input, combined into the word parity |
| en_n_i | input | 1 | Active-low enable for the flag register |
| hold_n_i | input | 1 | Active-low hold for the flag register |
| shift_i | input | 1 | Active-high shift select for the flag register |
| scan_i | input | 1 | Serial scan input to the flag register |
| chk_o | output | 4 | Hamming check bits; bit 0 is the first check bit |
| byte_par_o | output | 1 | Parity of the whole byte |
| word_par_o | output | 1 | Word parity after sense select and gating |
| err_o | output | 1 | Registered error flag |
| err_n_o | output | 1 | Complement of the error flag |

## Verification
The check bits, the byte parity and the word parity have no register in their path. They are sampled one nanosecond after the inputs change, inside the same low clock phase, over every byte value combined with both parity senses and both gate values. The flag changes one clock edge after its controls are applied. Every control combination is therefore driven on a falling edge and checked on the next falling edge against a bench model that has been updated once. The reset check samples while reset is still low, and again after the release delay of two clock edges.

// File: rtl/hamming_parity_pkg.sv
package hamming_parity_pkg;

  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;

  // Coverage of each check bit over the data byte. Data bit 0 is in none.
  function automatic logic [DATA_W-1:0] chk_mask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      0:       m = 8'b1010_1010;
      1:       m = 8'b1100_1100;
      2:       m = 8'b1111_0000;
      3:       m = 8'b1001_0110;
      default: m = '0;
    endcase
    return m;
  endfunction

  typedef enum logic [1:0] {
    FLAG_KEEP  = 2'd0,
    FLAG_SCAN  = 2'd1,
    FLAG_LOAD  = 2'd2
  } flag_op_e;

endpackage

// File: rtl/hamming_check_gen.sv
module hamming_check_gen
  import hamming_parity_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o,
  output logic          byte_par_o
);

  for (genvar gi = 0; gi < CW; gi++) begin : g_chk
    localparam logic [DW-1:0] MASK = chk_mask(gi);
    assign chk_o[gi] = ^(data_i & MASK);
  end

  assign byte_par_o = ^data_i;

endmodule

// File: rtl/hamming_word_par.sv
module hamming_word_par (
  input  logic byte_par_i,
  input  logic bpar_i,
  input  logic odd_sel_i,
  output logic word_par_o
);

  logic sensed;

  always_comb begin
    sensed     = byte_par_i ^ odd_sel_i;
    word_par_o = sensed ^ bpar_i;
  end

endmodule

// File: rtl/hamming_scan_flag.sv
module hamming_scan_flag
  import hamming_parity_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_n_i,
  input  logic shift_i,
  input  logic hold_n_i,
  input  logic scan_i,
  input  logic load_d_i,
  output logic flag_o
);

  flag_op_e op;
  logic     flag_q;
  logic     flag_d;

  always_comb begin
    if (en_n_i)        op = FLAG_KEEP;
    else if (shift_i)  op = FLAG_SCAN;
    else if (!hold_n_i) op = FLAG_KEEP;
    else               op = FLAG_LOAD;
  end

  always_comb begin
    case (op)
      FLAG_SCAN: flag_d = scan_i;
      FLAG_LOAD: flag_d = load_d_i;
      default:   flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r6_disabled_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |=> $stable(flag_o));

  a_r7_shift_takes_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && shift_i) |=> (flag_o == $past(scan_i)));

  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && !shift_i && !hold_n_i) |=> $stable(flag_o));

  a_r9_load_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && !shift_i && hold_n_i) |=> (flag_o == $past(load_d_i)));

endmodule

// File: rtl/hamming_parity_scan.sv
module hamming_parity_scan
  import hamming_parity_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_sel_i,
  input  logic              bpar_i,
  input  logic              en_n_i,
  input  logic              hold_n_i,
  input  logic              shift_i,
  input  logic              scan_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              byte_par_o,
  output logic              word_par_o,
  output logic              err_o,
  output logic              err_n_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   flag;

  // Reset asserts at once and releases after SYNC_STAGES edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  hamming_check_gen #(
    .DW(DATA_W),
    .CW(CHK_W)
  ) u_chk (
    .data_i    (data_i),
    .chk_o     (chk_o),
    .byte_par_o(byte_par_o)
  );

  hamming_word_par u_wpar (
    .byte_par_i(byte_par_o),
    .bpar_i    (bpar_i),
    .odd_sel_i (odd_sel_i),
    .word_par_o(word_par_o)
  );

  hamming_scan_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_n_i  (en_n_i),
    .shift_i (shift_i),
    .hold_n_i(hold_n_i),
    .scan_i  (scan_i),
    .load_d_i(word_par_o),
    .flag_o  (flag)
  );

  assign err_o   = flag;
  assign err_n_o = ~flag;

  a_r10_flag_clear_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> !err_o);

  a_r11_complement_pair: assert property (@(posedge clk) disable iff (!rst_n)
    err_n_o != err_o);

endmodule

// File: tb/hamming_parity_scan_tb_top.sv
module hamming_parity_scan_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] data;
  logic       odd_sel, bpar, en_n, hold_n, shift, scan;
  logic [3:0] chk;
  logic       byte_par, word_par, err, err_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic model_flag;

  always #5 clk = ~clk;

  hamming_parity_scan dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (data),
    .odd_sel_i (odd_sel),
    .bpar_i    (bpar),
    .en_n_i    (en_n),
    .hold_n_i  (hold_n),
    .shift_i   (shift),
    .scan_i    (scan),
    .chk_o     (chk),
    .byte_par_o(byte_par),
    .word_par_o(word_par),
    .err_o     (err),
    .err_n_o   (err_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_wpar(input logic [7:0] d, input logic o, input logic g);
    int ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(d[k]);
    ones += int'(g);
    return logic'((ones % 2) != 0) ^ o;
  endfunction

  // Apply one flag control set on a falling edge, check on the next one.
  task automatic flag_step(input logic e, input logic s, input logic h,
                           input logic si, input logic [7:0] d,
                           input logic o, input logic g);
    logic nxt;
    en_n = e; shift = s; hold_n = h; scan = si; data = d; odd_sel = o; bpar = g;
    if (e)       nxt = model_flag;          // R6
    else if (s)  nxt = si;                  // R7
    else if (!h) nxt = model_flag;          // R8
    else         nxt = exp_wpar(d, o, g);   // R9
    @(negedge clk);
    model_flag = nxt;
    if (e)       check("R6 disabled keeps", {7'd0, err}, {7'd0, nxt});
    else if (s)  check("R7 shift loads scan", {7'd0, err}, {7'd0, nxt});
    else if (!h) check("R8 hold keeps", {7'd0, err}, {7'd0, nxt});
    else         check("R9 load word parity", {7'd0, err}, {7'd0, nxt});
    check("R11 complement", {7'd0, err_n}, {7'd0, ~nxt});
  endtask

  initial begin
    rst_n = 1'b0; data = '0; odd_sel = 0; bpar = 0;
    en_n = 1; hold_n = 1; shift = 0; scan = 0;
    model_flag = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 flag in reset", {7'd0, err}, 8'd0);
    check("R10 complement in reset", {7'd0, err_n}, 8'd1);

    // R12 and R1-R5: combinational sweep with the clock running.
    for (int v = 0; v < 1024; v++) begin
      logic [7:0] d;
      logic e1, e2, e3, e4, e5;
      d = v[7:0];
      data = d; odd_sel = v[8]; bpar = v[9];
      #1;
      e1 = d[1] ^ d[3] ^ d[5] ^ d[7];
      e2 = d[2] ^ d[3] ^ d[6] ^ d[7];
      e3 = d[4] ^ d[5] ^ d[6] ^ d[7];
      e4 = d[1] ^ d[2] ^ d[4] ^ d[7];
      e5 = ^d;
      check("R1 chk0", {7'd0, chk[0]}, {7'd0, e1});
      check("R2 chk1", {7'd0, chk[1]}, {7'd0, e2});
      check("R3 chk2", {7'd0, chk[2]}, {7'd0, e3});
      check("R3 chk3", {7'd0, chk[3]}, {7'd0, e4});
      check("R4 byte parity", {7'd0, byte_par}, {7'd0, e5});
      check("R5 R12 word parity", {7'd0, word_par}, {7'd0, exp_wpar(d, v[8], v[9])});
    end

    // Release reset, still inside the reset window.
    @(negedge clk);
    rst_n = 1'b1;
    en_n = 0; shift = 1; scan = 1;
    @(negedge clk);
    check("R10 flag held one edge after release", {7'd0, err}, 8'd0);
    @(negedge clk);
    check("R10 flag held two edges after release", {7'd0, err}, 8'd0);
    en_n = 1; shift = 0; scan = 0;
    @(negedge clk);
    model_flag = 1'b0;

    // Every control combination, across several data patterns.
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] d;
        d = 8'(c * 37 + r * 91 + 5);
        flag_step(c[0], c[1], c[2], c[3], d, r[0], r[1]);
      end
    end
    // Directed: set flag through the parity load, then shift and hold stay put.
    flag_step(0, 0, 1, 0, 8'h01, 0, 0);   // R9: parity of one bit gives 1
    flag_step(1, 1, 1, 0, 8'h00, 0, 0);   // R6: shift ignored while disabled
    flag_step(0, 0, 0, 0, 8'h00, 0, 0);   // R8: hold keeps the 1
    flag_step(0, 1, 0, 0, 8'h00, 0, 0);   // R7: shift overrides hold
    flag_step(0, 0, 1, 0, 8'h00, 1, 0);   // R9: odd sense on an empty byte
    flag_step(0, 0, 1, 0, 8'hFF, 0, 1);   // R9: gate flips an even byte

    // Asynchronous reset while the flag is set.
    flag_step(0, 1, 1, 1, 8'h00, 0, 0);
    #2 rst_n = 1'b0;
    #1;
    check("R10 async clear", {7'd0, err}, 8'd0);
    check("R10 async complement", {7'd0, err_n}, 8'd1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule